// File: doc/BRIEF.md
# Virtual Port Window Mapper

This block gives a processor a compact, low-address alias for up to four of its 8-bit I/O ports. A 16-address window is split into four slots of four addresses. Each slot is a virtual port, and each virtual port has a map-select register that names the real port it mirrors. A window access is routed to the mirrored port's direction, output, input or flag register. That register answers or takes the write exactly as it would for an access at the port's own address.

The block owns only the map-select registers, the window decode, the read-data selection and the forwarding of write strobes. The real port registers live outside. They present their current values on flat buses and accept a one-hot write strobe, a register code and a data byte.

Reads come back in the same cycle through combinational selection. Writes are registered once on the way out. A real-port register that latches the forwarded strobe therefore shows the new value two rising edges after the write was issued. The map can be changed at any time, so any real port can be moved into any slot at run time.

Top module: `vport_mapper`

## Requirements
- R1: After reset, every virtual port is mapped to real port 0 and no forward strobe is active.
- R2: A map write with `map_we` high loads `map_wdata` into the map register of virtual port `map_idx`, taking effect from the next cycle. The other map registers are unchanged, and map registers hold their value when `map_we` is low.
- R3: A window address is decoded as follows. Bits [3:2] select the virtual port. Bits [1:0] select the register: 0 is direction, 1 is output, 2 is input and 3 is flags.
- R4: When `win_sel` is high and `win_we` is low, `win_rdata` returns, in the same cycle, the addressed register of the real port that the addressed virtual port maps to.
- R5: When no window read is in progress (`win_sel` low, or a write), `win_rdata` is 0.
- R6: A window write (`win_sel` and `win_we` high) produces, in the next cycle, a one-hot `fw_we` at the mapped real port, with `fw_reg` equal to address bits [1:0] and `fw_data` equal to the written byte. In every other cycle `fw_we` is all zero, and at most one bit is ever set.
- R7: A real-port register that latches the forwarded write holds the new value after the second rising edge following the write cycle.
- R8: A window access in the same cycle as a map write to the same virtual port uses the mapping from before that map write.
- R9: Two virtual ports mapped to the same real port both read and write that port.
- R10: Window writes in consecutive cycles are each forwarded, in order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_sel | input | 1 | Window access this cycle |
| win_we | input | 1 | Window access is a write |
| win_addr | input | 4 | Window address: virtual port in [3:2], register in [1:0] |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data (0 when not reading) |
| map_we | input | 1 | Map-select register write |
| map_idx | input | 2 | Virtual port whose map register is written |
| map_wdata | input | 2 | Real port number to map |
| pr_dir | input | 32 | Direction registers of all real ports, port p in [8p+7:8p] |
| pr_out | input | 32 | Output registers of all real ports |
| pr_in | input | 32 | Input values of all real ports |
| pr_flg | input | 32 | Interrupt flag registers of all real ports |
| fw_we | output | 4 | One-hot forwarded write strobe, bit p for real port p |
| fw_reg | output | 2 | Register code of the forwarded write |
| fw_data | output | 8 | Data of the forwarded write |

## Verification
The bench first remaps the slots to a permutation of the ports and then reads all sixteen addresses. A wrong slot or register decode would return another port's byte. It issues a window write in the same cycle as a remap of that slot. A design that let the new map win would strobe the wrong port. It also points several slots at one port and writes through them back to back, which exposes dropped or merged forwards. It compares the externally latched output registers with a model every cycle, so an extra or missing stage in the write path shows up as a value that appears one edge early or late. Reads while idle and during writes must return zero, and writes to the input code must reach the port only as a strobe.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  localparam int REGS_PER_VP = 4;

  typedef enum logic [1:0] {
    VR_DIR = 2'd0,
    VR_OUT = 2'd1,
    VR_IN  = 2'd2,
    VR_FLG = 2'd3
  } vreg_e;

  function automatic vreg_e reg_of(input logic [1:0] low);
    return vreg_e'(low);
  endfunction

  function automatic int unsigned lane_base(input int unsigned port, input int unsigned width);
    return port * width;
  endfunction

endpackage

// File: rtl/vpm_map_regs.sv
module vpm_map_regs #(
  parameter int NVP = 4,
  parameter int PW  = 2,
  localparam int VW = $clog2(NVP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [VW-1:0]     idx,
  input  logic [PW-1:0]     wdata,
  output logic [NVP*PW-1:0] map_flat
);

  for (genvar v = 0; v < NVP; v++) begin : g_slot
    logic [PW-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q <= '0;
      end else if (we && (idx == VW'(v))) begin
        sel_q <= wdata;
      end
    end
    assign map_flat[v*PW +: PW] = sel_q;
  end

endmodule

// File: rtl/vpm_decode.sv
module vpm_decode #(
  parameter int NVP = 4,
  parameter int PW  = 2,
  localparam int VW = $clog2(NVP),
  localparam int AW = VW + 2
) (
  input  logic              win_sel,
  input  logic              win_we,
  input  logic [AW-1:0]     win_addr,
  input  logic [NVP*PW-1:0] map_flat,
  output logic [PW-1:0]     tgt_port,
  output vpm_pkg::vreg_e    reg_sel,
  output logic              rd_en,
  output logic              wr_en
);

  logic [VW-1:0] vp;

  assign vp       = win_addr[AW-1:2];
  assign tgt_port = map_flat[vp*PW +: PW];
  assign reg_sel  = vpm_pkg::reg_of(win_addr[1:0]);
  assign rd_en    = win_sel & ~win_we;
  assign wr_en    = win_sel & win_we;

endmodule

// File: rtl/vpm_rd_mux.sv
module vpm_rd_mux #(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  localparam int PW   = $clog2(NPORT)
) (
  input  logic                rd_en,
  input  logic [PW-1:0]       tgt_port,
  input  vpm_pkg::vreg_e      reg_sel,
  input  logic [NPORT*DW-1:0] pr_dir,
  input  logic [NPORT*DW-1:0] pr_out,
  input  logic [NPORT*DW-1:0] pr_in,
  input  logic [NPORT*DW-1:0] pr_flg,
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] lane [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    always_comb begin
      unique case (reg_sel)
        vpm_pkg::VR_DIR: lane[p] = pr_dir[p*DW +: DW];
        vpm_pkg::VR_OUT: lane[p] = pr_out[p*DW +: DW];
        vpm_pkg::VR_IN:  lane[p] = pr_in[p*DW +: DW];
        default:         lane[p] = pr_flg[p*DW +: DW];
      endcase
    end
  end

  assign rdata = rd_en ? lane[tgt_port] : '0;

endmodule

// File: rtl/vpm_wr_fwd.sv
module vpm_wr_fwd #(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  localparam int PW   = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    tgt_port,
  input  vpm_pkg::vreg_e   reg_sel,
  input  logic [DW-1:0]    wdata,
  output logic [NPORT-1:0] fw_we,
  output logic [1:0]       fw_reg,
  output logic [DW-1:0]    fw_data
);

  logic [NPORT-1:0] we_nxt;

  for (genvar p = 0; p < NPORT; p++) begin : g_strobe
    assign we_nxt[p] = wr_en && (tgt_port == PW'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fw_we   <= '0;
      fw_reg  <= 2'd0;
      fw_data <= '0;
    end else begin
      fw_we <= we_nxt;
      if (wr_en) begin
        fw_reg  <= reg_sel;
        fw_data <= wdata;
      end
    end
  end

endmodule

// File: rtl/vport_mapper.sv
module vport_mapper #(
  parameter int NVP   = 4,
  parameter int NPORT = 4,
  parameter int DW    = 8,
  localparam int VW   = $clog2(NVP),
  localparam int PW   = $clog2(NPORT),
  localparam int AW   = VW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_sel,
  input  logic                win_we,
  input  logic [AW-1:0]       win_addr,
  input  logic [DW-1:0]       win_wdata,
  output logic [DW-1:0]       win_rdata,
  input  logic                map_we,
  input  logic [VW-1:0]       map_idx,
  input  logic [PW-1:0]       map_wdata,
  input  logic [NPORT*DW-1:0] pr_dir,
  input  logic [NPORT*DW-1:0] pr_out,
  input  logic [NPORT*DW-1:0] pr_in,
  input  logic [NPORT*DW-1:0] pr_flg,
  output logic [NPORT-1:0]    fw_we,
  output logic [1:0]          fw_reg,
  output logic [DW-1:0]       fw_data
);

  logic [NVP*PW-1:0] map_flat;
  logic [PW-1:0]     tgt_port;
  vpm_pkg::vreg_e    reg_sel;
  logic              rd_en;
  logic              wr_en;

  vpm_map_regs #(.NVP(NVP), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .we(map_we), .idx(map_idx),
    .wdata(map_wdata), .map_flat(map_flat)
  );

  vpm_decode #(.NVP(NVP), .PW(PW)) u_dec (
    .win_sel(win_sel), .win_we(win_we), .win_addr(win_addr),
    .map_flat(map_flat), .tgt_port(tgt_port), .reg_sel(reg_sel),
    .rd_en(rd_en), .wr_en(wr_en)
  );

  vpm_rd_mux #(.NPORT(NPORT), .DW(DW)) u_rd (
    .rd_en(rd_en), .tgt_port(tgt_port), .reg_sel(reg_sel),
    .pr_dir(pr_dir), .pr_out(pr_out), .pr_in(pr_in), .pr_flg(pr_flg),
    .rdata(win_rdata)
  );

  vpm_wr_fwd #(.NPORT(NPORT), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgt_port(tgt_port),
    .reg_sel(reg_sel), .wdata(win_wdata),
    .fw_we(fw_we), .fw_reg(fw_reg), .fw_data(fw_data)
  );

endmodule

// File: rtl/vport_mapper_chk.sv
module vport_mapper_chk #(
  parameter int NVP   = 4,
  parameter int NPORT = 4,
  parameter int DW    = 8,
  localparam int PW   = $clog2(NPORT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [PW-1:0]     tgt_port,
  input logic [1:0]        addr_lo,
  input logic [DW-1:0]     win_wdata,
  input logic [DW-1:0]     win_rdata,
  input logic [NPORT-1:0]  fw_we,
  input logic [1:0]        fw_reg,
  input logic [DW-1:0]     fw_data,
  input logic              map_we,
  input logic [NVP*PW-1:0] map_flat
);

  AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fw_we)); // R6

  AST_FWD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fw_we == (NPORT'(1) << $past(tgt_port))); // R6

  AST_FWD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fw_data == $past(win_wdata)) && (fw_reg == $past(addr_lo))); // R6

  AST_FWD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> fw_we == '0); // R6

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> win_rdata == '0); // R5

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !map_we |=> $stable(map_flat)); // R2

endmodule

bind vport_mapper vport_mapper_chk #(.NVP(NVP), .NPORT(NPORT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .tgt_port(tgt_port), .addr_lo(win_addr[1:0]), .win_wdata(win_wdata),
  .win_rdata(win_rdata), .fw_we(fw_we), .fw_reg(fw_reg), .fw_data(fw_data),
  .map_we(map_we), .map_flat(map_flat)
);

// File: tb/tb_vport_mapper.sv
`timescale 1ns/1ps
module tb_vport_mapper;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        win_sel = 1'b0, win_we = 1'b0, map_we = 1'b0;
  logic [3:0]  win_addr = '0;
  logic [7:0]  win_wdata = '0;
  logic [1:0]  map_idx = '0, map_wdata = '0;
  logic [31:0] pr_dir, pr_out, pr_in, pr_flg;
  logic [7:0]  win_rdata, fw_data;
  logic [3:0]  fw_we;
  logic [1:0]  fw_reg;

  vport_mapper dut (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_we(win_we),
    .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
    .pr_dir(pr_dir), .pr_out(pr_out), .pr_in(pr_in), .pr_flg(pr_flg),
    .fw_we(fw_we), .fw_reg(fw_reg), .fw_data(fw_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // external real ports (hardware side, driven by the DUT strobes)
  logic [7:0] h_dir [4], h_out [4], h_flg [4];
  logic [7:0] pin_v [4];
  // reference model
  logic [7:0] m_dir [4], m_out [4], m_flg [4];
  logic [1:0] m_map [4];
  bit         pend_v = 1'b0;
  int         pend_p = 0, pend_r = 0;
  logic [7:0] pend_d = '0;

  function automatic logic [7:0] preset(int p, int r);
    case (r)
      0:       return 8'(8'h11 * (p + 1));
      1:       return 8'(8'hA0 + p);
      default: return 8'(8'hF0 ^ (p * 8'h13));
    endcase
  endfunction

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      pr_dir[p*8 +: 8] = h_dir[p];
      pr_out[p*8 +: 8] = h_out[p];
      pr_in[p*8 +: 8]  = pin_v[p];
      pr_flg[p*8 +: 8] = h_flg[p];
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < 4; p++) begin
      if (!rst_n) begin
        h_dir[p] <= preset(p, 0);
        h_out[p] <= preset(p, 1);
        h_flg[p] <= preset(p, 3);
      end else if (fw_we[p]) begin
        case (fw_reg)
          2'd0: h_dir[p] <= fw_data;
          2'd1: h_out[p] <= fw_data;
          2'd3: h_flg[p] <= h_flg[p] & ~fw_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] mreg(int p, int r);
    case (r)
      0:       return m_dir[p];
      1:       return m_out[p];
      2:       return pin_v[p];
      default: return m_flg[p];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit w, input int a, input logic [7:0] d,
                      input bit mw, input int mi, input int md, input string tag);
    logic [7:0] exp_rd;
    logic [3:0] exp_we;
    logic [31:0] hpack, mpack;
    win_sel = s; win_we = w; win_addr = 4'(a); win_wdata = d;
    map_we = mw; map_idx = 2'(mi); map_wdata = 2'(md);
    @(negedge clk);
    exp_rd = (s && !w) ? mreg(int'(m_map[a/4]), a % 4) : 8'h00;
    chk(win_rdata == exp_rd, (s && !w) ? {"R4 ", tag} : {"R5 ", tag}, 32'(win_rdata), 32'(exp_rd));
    exp_we = pend_v ? 4'(1 << pend_p) : 4'b0;
    chk(fw_we == exp_we, {"R6 strobe ", tag}, 32'(fw_we), 32'(exp_we));
    if (pend_v) begin
      chk({fw_reg, fw_data} == {2'(pend_r), pend_d}, {"R6 payload ", tag},
          32'({fw_reg, fw_data}), 32'({2'(pend_r), pend_d}));
    end
    for (int p = 0; p < 4; p++) begin
      hpack[p*8 +: 8] = h_out[p];
      mpack[p*8 +: 8] = m_out[p];
    end
    chk(hpack == mpack, {"R7 ", tag}, hpack, mpack);
    @(posedge clk);
    if (pend_v) begin
      case (pend_r)
        0: m_dir[pend_p] = pend_d;
        1: m_out[pend_p] = pend_d;
        3: m_flg[pend_p] = m_flg[pend_p] & ~pend_d;
        default: ;
      endcase
    end
    pend_v = s && w;
    pend_p = int'(m_map[a/4]);
    pend_r = a % 4;
    pend_d = d;
    if (mw) m_map[mi] = 2'(md);
    #1;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 0, 8'h00, 1'b0, 0, 0, tag);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      m_dir[p] = preset(p, 0);
      m_out[p] = preset(p, 1);
      m_flg[p] = preset(p, 3);
      m_map[p] = 2'd0;
      pin_v[p] = 8'(8'h50 + p);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fw_we == 4'b0, "R1 strobe in reset", 32'(fw_we), 32'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: every slot reads real port 0 after reset
    for (int v = 0; v < 4; v++) step(1'b1, 1'b0, v*4, 8'h00, 1'b0, 0, 0, "R1");
    // R3: full window decode with identity-to-port-0 map
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, a, 8'h00, 1'b0, 0, 0, "R3");
    // R2: remap three slots, slot 0 untouched
    step(1'b0, 1'b0, 0, 8'h00, 1'b1, 1, 2, "R2");
    step(1'b0, 1'b0, 0, 8'h00, 1'b1, 2, 3, "R2");
    step(1'b0, 1'b0, 0, 8'h00, 1'b1, 3, 1, "R2");
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, a, 8'h00, 1'b0, 0, 0, "R2");
    // R4: input value follows the pin in the same cycle
    pin_v[3] = 8'h5A;
    step(1'b1, 1'b0, 4*2 + 2, 8'h00, 1'b0, 0, 0, "R4");
    pin_v[3] = 8'hC6;
    step(1'b1, 1'b0, 4*2 + 2, 8'h00, 1'b0, 0, 0, "R4");
    // R6 / R7: output write through slot 1 reaches port 2
    step(1'b1, 1'b1, 4*1 + 1, 8'hC3, 1'b0, 0, 0, "R6");
    idle("R7");
    idle("R7");
    step(1'b1, 1'b0, 4*1 + 1, 8'h00, 1'b0, 0, 0, "R7");
    // flag clear through slot 3 (port 1), direction via slot 0
    step(1'b1, 1'b1, 4*3 + 3, 8'h0F, 1'b0, 0, 0, "R6");
    step(1'b1, 1'b1, 4*0 + 0, 8'h3C, 1'b0, 0, 0, "R6");
    idle("R6");
    step(1'b1, 1'b0, 4*3 + 3, 8'h00, 1'b0, 0, 0, "R6");
    step(1'b1, 1'b0, 4*0 + 0, 8'h00, 1'b0, 0, 0, "R6");
    // write to input code: strobe only
    step(1'b1, 1'b1, 4*2 + 2, 8'hFF, 1'b0, 0, 0, "R6");
    idle("R6");
    step(1'b1, 1'b0, 4*2 + 2, 8'h00, 1'b0, 0, 0, "R6");
    // R8: same-cycle remap of slot 2 (port 3 -> port 0) and write via slot 2
    step(1'b1, 1'b1, 4*2 + 1, 8'h77, 1'b1, 2, 0, "R8");
    idle("R8");
    step(1'b1, 1'b0, 4*2 + 1, 8'h00, 1'b0, 0, 0, "R8");
    // R9: slots 0, 1, 2 all on port 0
    step(1'b0, 1'b0, 0, 8'h00, 1'b1, 1, 0, "R9");
    step(1'b1, 1'b1, 4*0 + 1, 8'h12, 1'b0, 0, 0, "R9");
    step(1'b1, 1'b1, 4*1 + 1, 8'h34, 1'b0, 0, 0, "R9");
    idle("R9");
    step(1'b1, 1'b0, 4*2 + 1, 8'h00, 1'b0, 0, 0, "R9");
    // R10: back-to-back writes to different ports
    step(1'b0, 1'b0, 0, 8'h00, 1'b1, 1, 2, "R10");
    step(1'b1, 1'b1, 4*0 + 0, 8'hA1, 1'b0, 0, 0, "R10");
    step(1'b1, 1'b1, 4*1 + 0, 8'hB2, 1'b0, 0, 0, "R10");
    step(1'b1, 1'b1, 4*3 + 1, 8'hC4, 1'b0, 0, 0, "R10");
    step(1'b1, 1'b1, 4*1 + 1, 8'hD5, 1'b0, 0, 0, "R10");
    idle("R10");
    idle("R10");
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, a, 8'h00, 1'b0, 0, 0, "R10");
    // R5: address present but no read
    step(1'b0, 1'b0, 4*1 + 1, 8'h00, 1'b0, 0, 0, "R5");
    step(1'b0, 1'b1, 4*3 + 0, 8'h99, 1'b0, 0, 0, "R5");
    idle("R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule